// File: doc/BRIEF.md
# Bit-Sliced Opcode ALU

This block is a purely combinational arithmetic and logic unit for two unsigned operands of `WIDTH` bits (16 by default). It is built from identical one-bit slices. A single decoder turns a 3-bit operation code into four shared controls: an enable that complements operand A, an enable that complements operand B, a two-bit result selector, and the carry fed into the lowest slice.

Each slice applies the optional complements and forms the AND, OR and XOR of the conditioned bits, plus their full-adder sum. It then picks one of the four results. Carries pass upward one slice at a time. Subtraction comes from complementing B and forcing the low carry to one. NOR comes from complementing both operands and choosing the AND result. The carry-out flag shows the carry from the top slice, but only while the adder result is selected.

Top module: `sliced_alu`

## Requirements
- R1: Opcode 3'b000 gives `result = a & b` and `carry_out = 0`.
- R2: Opcode 3'b001 gives `result = a | b` and `carry_out = 0`.
- R3: Opcode 3'b011 gives `result = (a + b) mod 2^WIDTH`, and `carry_out` equals bit WIDTH of the full sum `a + b`.
- R4: Opcode 3'b010 gives `result = (a + ~b + 1) mod 2^WIDTH`, and `carry_out` equals bit WIDTH of that full sum. The flag is therefore 1 exactly when a >= b taken as unsigned.
- R5: Opcode 3'b101 gives `result = ~(a | b)` and `carry_out = 0`.
- R6: Opcode 3'b100 gives `result = a ^ b` and `carry_out = 0`.
- R7: Opcodes 3'b110 and 3'b111 behave exactly like 3'b000: the result is `a & b` and `carry_out = 0`.
- R8: `carry_out` is 0 for every opcode other than 3'b010 and 3'b011, whatever the operands and however far a carry would ripple.
- R9: The outputs depend only on the present inputs. A change of inputs shows on the outputs within the same time step, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| opcode | input | 3 | Operation code |
| result | output | WIDTH | Selected slice results |
| carry_out | output | 1 | Top-slice carry while the adder is selected, else 0 |

## Verification
The hardest case to reach is a carry that travels the full length of the chain. Examples are 0xFFFF plus 1, and subtraction of equal operands, where every slice propagates. Random operands almost never produce a full-length ripple, so directed corner pairs built from 0, 1, 0x8000 and 0xFFFF are applied under every opcode. The same corner pairs are applied under the non-adder opcodes, to show that a full-length carry never reaches the flag there. A change of inputs that is sampled before any clock edge covers the combinational response.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_SUB  = 3'b010,
        OP_ADD  = 3'b011,
        OP_XOR  = 3'b100,
        OP_NOR  = 3'b101,
        OP_RSV0 = 3'b110,
        OP_RSV1 = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        PICK_AND = 2'b00,
        PICK_OR  = 2'b01,
        PICK_SUM = 2'b10,
        PICK_XOR = 2'b11
    } pick_e;

    typedef struct packed {
        logic  flip_a;
        logic  flip_b;
        pick_e pick;
        logic  low_carry;
    } alu_ctrl_t;

endpackage

// File: rtl/alu_decoder.sv
module alu_decoder
    import alu_pkg::*;
(
    input  logic [2:0] opcode,
    output alu_ctrl_t  ctrl
);

    always_comb begin
        ctrl = '{flip_a: 1'b0, flip_b: 1'b0, pick: PICK_AND, low_carry: 1'b0};
        case (alu_op_e'(opcode))
            OP_AND: ctrl.pick = PICK_AND;
            OP_OR:  ctrl.pick = PICK_OR;
            OP_ADD: ctrl.pick = PICK_SUM;
            OP_SUB: begin
                ctrl.pick      = PICK_SUM;
                ctrl.flip_b    = 1'b1;
                ctrl.low_carry = 1'b1;
            end
            OP_NOR: begin
                ctrl.pick   = PICK_AND;
                ctrl.flip_a = 1'b1;
                ctrl.flip_b = 1'b1;
            end
            OP_XOR: ctrl.pick = PICK_XOR;
            default: ctrl.pick = PICK_AND;
        endcase
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic  a_bit,
    input  logic  b_bit,
    input  logic  flip_a,
    input  logic  flip_b,
    input  pick_e pick,
    input  logic  c_in,
    output logic  x_out,
    output logic  y_out,
    output logic  r_out
);

    logic x_bit;
    logic y_bit;
    logic sum_bit;

    always_comb begin
        x_bit   = a_bit ^ flip_a;
        y_bit   = b_bit ^ flip_b;
        sum_bit = x_bit ^ y_bit ^ c_in;
        case (pick)
            PICK_AND: r_out = x_bit & y_bit;
            PICK_OR:  r_out = x_bit | y_bit;
            PICK_SUM: r_out = sum_bit;
            default:  r_out = x_bit ^ y_bit;
        endcase
    end

    assign x_out = x_bit;
    assign y_out = y_bit;

endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_vec,
    input  logic [WIDTH-1:0] y_vec,
    input  logic             c_low,
    output logic [WIDTH:0]   c_vec
);

    always_comb begin
        logic [WIDTH:0] c_tmp;
        c_tmp[0] = c_low;
        for (int i = 0; i < WIDTH; i++) begin
            c_tmp[i+1] = (x_vec[i] & y_vec[i]) |
                         (x_vec[i] & c_tmp[i]) |
                         (y_vec[i] & c_tmp[i]);
        end
        c_vec = c_tmp;
    end

endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       opcode,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int TOP = WIDTH;

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] x_vec;
    logic [WIDTH-1:0] y_vec;
    logic [WIDTH:0]   c_vec;

    alu_decoder dec_i (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    for (genvar g = 0; g < WIDTH; g++) begin : g_slice
        alu_slice slice_i (
            .a_bit  (a[g]),
            .b_bit  (b[g]),
            .flip_a (ctrl.flip_a),
            .flip_b (ctrl.flip_b),
            .pick   (ctrl.pick),
            .c_in   (c_vec[g]),
            .x_out  (x_vec[g]),
            .y_out  (y_vec[g]),
            .r_out  (result[g])
        );
    end

    alu_carry_chain #(.WIDTH(WIDTH)) chain_i (
        .x_vec (x_vec),
        .y_vec (y_vec),
        .c_low (ctrl.low_carry),
        .c_vec (c_vec)
    );

    assign carry_out = (ctrl.pick == PICK_SUM) ? c_vec[TOP] : 1'b0;

endmodule

// File: rtl/sliced_alu_chk.sv
module sliced_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [2:0]       opcode,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);

    logic [WIDTH:0] add_ref;
    logic [WIDTH:0] sub_ref;

    always_comb begin
        add_ref = {1'b0, a} + {1'b0, b};
        sub_ref = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};

        if (opcode == 3'b000)
            a_r1_and: assert (result == (a & b)) else $error("R1 AND mismatch");
        if (opcode == 3'b001)
            a_r2_or: assert (result == (a | b)) else $error("R2 OR mismatch");
        if (opcode == 3'b011)
            a_r3_add: assert ({carry_out, result} == add_ref) else $error("R3 ADD mismatch");
        if (opcode == 3'b010)
            a_r4_sub: assert ({carry_out, result} == sub_ref) else $error("R4 SUB mismatch");
        if (opcode == 3'b101)
            a_r5_nor: assert (result == ~(a | b)) else $error("R5 NOR mismatch");
        if (opcode == 3'b100)
            a_r6_xor: assert (result == (a ^ b)) else $error("R6 XOR mismatch");
        if (opcode[2:1] == 2'b11)
            a_r7_spare: assert (result == (a & b)) else $error("R7 spare opcode mismatch");
        if (opcode[2:1] != 2'b01)
            a_r8_flag_quiet: assert (carry_out == 1'b0) else $error("R8 carry flag set");
    end

endmodule

bind sliced_alu sliced_alu_chk #(.WIDTH(WIDTH)) chk_i (
    .a         (a),
    .b         (b),
    .opcode    (opcode),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/sliced_alu_tb_top.sv
module sliced_alu_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   opcode = 3'b000;
    logic [W-1:0] result;
    logic         carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sliced_alu #(.WIDTH(W)) dut_i (
        .a         (a),
        .b         (b),
        .opcode    (opcode),
        .result    (result),
        .carry_out (carry_out)
    );

    function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
        case (op)
            3'b001:  return {1'b0, x | y};
            3'b011:  return {1'b0, x} + {1'b0, y};
            3'b010:  return {1'b0, x} + {1'b0, ~y} + 17'd1;
            3'b101:  return {1'b0, ~(x | y)};
            3'b100:  return {1'b0, x ^ y};
            default: return {1'b0, x & y};
        endcase
    endfunction

    function automatic string tag(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b011:  return "R3";
            3'b010:  return "R4";
            3'b101:  return "R5";
            3'b100:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: op=%b a=%h b=%h got carry/result=%h expected=%h",
                     req, opcode, a, b, got, exp);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        opcode = op;
        a = x;
        b = y;
        @(negedge clk);
        check(tag(op), {carry_out, result}, model(op, x, y));
        if (op[2:1] != 2'b01)
            check("R8", {16'd0, carry_out}, 17'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] corners [4];
        int unsigned seed;
        corners[0] = 16'h0000;
        corners[1] = 16'h0001;
        corners[2] = 16'h8000;
        corners[3] = 16'hFFFF;
        seed = 32'd7391;
        void'($urandom(seed));

        // idle state with all-zero inputs: AND of zeros, flag low (R1)
        @(negedge clk);
        check("R1", {carry_out, result}, 17'd0);

        // R9: change inputs between edges and observe before any edge
        @(negedge clk);
        opcode = 3'b011;
        a = 16'hFFFF;
        b = 16'h0001;
        #1;
        check("R9", {carry_out, result}, 17'h10000);

        // full-length ripple cases (R3, R4)
        apply(3'b011, 16'hFFFF, 16'h0001);
        apply(3'b010, 16'h1234, 16'h1234);
        apply(3'b010, 16'h0000, 16'h0001);
        apply(3'b010, 16'h8000, 16'h7FFF);

        // R8: carry-generating operands under non-adder opcodes
        apply(3'b000, 16'hFFFF, 16'hFFFF);
        apply(3'b101, 16'h0000, 16'h0000);
        apply(3'b110, 16'hFFFF, 16'h0001);
        apply(3'b111, 16'hA5A5, 16'hFFFF);

        // every opcode against every corner pair
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    apply(3'(op), corners[i], corners[j]);

        // constrained random: each opcode with random operands
        for (int k = 0; k < 800; k++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            x = W'($urandom);
            y = W'($urandom);
            if (k % 10 == 0) y = x;
            apply(3'($urandom % 8), x, y);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule